// File: doc/BRIEF.md
# Packed 16-bit dot-product accumulator

This unit is a vector datapath slice that folds pairs of 16-bit products into 32-bit accumulator lanes. Three packed operands arrive together: an accumulator vector with one 32-bit value per lane and two source vectors with two 16-bit elements per lane. Each lane multiplies its two element pairs, adds both products to its accumulator value, and writes a 32-bit lane result.

A 3-bit mode picks how the two sources are extended before multiplying and whether the lane sum wraps or clamps. The number of active lanes is a parameter, 4 or 8. The ports always carry the 8-lane width, and lanes above the configured count read as zero. The result is registered, and a valid strobe travels alongside it with one cycle of latency.

Top module: `pair_dot_accum`

## Requirements
- R1: Result lane j (bits [32j+31:32j]) equals the accumulator lane plus srcA element 2j times srcB element 2j, plus srcA element 2j+1 times srcB element 2j+1. Element 2j sits at bits [32j+15:32j] and element 2j+1 at bits [32j+31:32j+16].
- R2: With mode[1:0]=00, srcA elements are sign-extended, srcB elements are zero-extended, and the accumulator is signed.
- R3: With mode[1:0]=01, srcA elements are zero-extended, srcB elements are sign-extended, and the accumulator is signed.
- R4: With mode[1:0]=10, both sources are zero-extended and the accumulator and result are unsigned 32-bit values.
- R5: With mode[2]=0, each lane result is the exact sum truncated to its low 32 bits (wraparound).
- R6: With mode[2]=1 and mode[1:0] of 00 or 01, each lane result is clamped to the range 0x80000000 through 0x7FFFFFFF, read as signed.
- R7: With mode[2]=1 and mode[1:0]=10, each lane result is clamped to at most 0xFFFFFFFF.
- R8: Result bits at and above 32*LANES are always zero.
- R9: With mode[1:0]=11, every result lane loaded is zero.
- R10: The result register loads only in a cycle with inValid high and holds otherwise. outValid is high exactly one cycle after each cycle with inValid high.
- R11: A synchronous active-high reset clears outValid and the whole result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and mode present this cycle |
| mode | input | 3 | [1:0] extension pairing, [2] saturate enable |
| accIn | input | 256 | Accumulator, 32-bit lanes |
| srcA | input | 256 | First source, 16-bit elements |
| srcB | input | 256 | Second source, 16-bit elements |
| outValid | output | 1 | Result register holds a fresh result |
| result | output | 256 | Registered lane results |

## Verification
Clamping in one lane and plain pass-through in a neighbouring lane can happen in the same operation. The forced zero of the lanes above LANES can also coincide with an overflowing active lane. The bench provokes both with one vector: lane 0 is driven far past the positive limit, lane 1 gets small operands, lane 2 overflows negative, and the unused upper lanes carry all-ones inputs. Each lane is then judged on its own against an extended-precision model, so a clamp that leaks across lanes or into the padding shows up as a lane mismatch.

// File: rtl/pda_pkg.sv
package pda_pkg;

  // Extension pairing carried in mode[1:0]
  typedef enum logic [1:0] {
    PAIR_SU   = 2'b00,
    PAIR_US   = 2'b01,
    PAIR_UU   = 2'b10,
    PAIR_NONE = 2'b11
  } pair_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic aSigned;
    logic bSigned;
    logic accSigned;
    logic satEn;
    logic zeroOut;
  } ctrl_t;

endpackage

// File: rtl/pda_ctrl.sv
module pda_ctrl
  import pda_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [2:0] mode,
  output ctrl_t      strobes,
  output logic       outValid
);

  pair_e pairSel;

  always_comb begin
    pairSel = pair_e'(mode[1:0]);
    strobes = '0;
    strobes.loadEn = inValid;
    strobes.satEn  = mode[2];
    unique case (pairSel)
      PAIR_SU: begin
        strobes.aSigned   = 1'b1;
        strobes.accSigned = 1'b1;
      end
      PAIR_US: begin
        strobes.bSigned   = 1'b1;
        strobes.accSigned = 1'b1;
      end
      PAIR_UU: ;
      default: begin
        strobes.zeroOut   = 1'b1;
        strobes.accSigned = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/pda_datapath.sv
module pda_datapath
  import pda_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_LANES = 8,
  parameter int ELEM_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrl_t                        strobes,
  input  logic [MAX_LANES*2*ELEM_W-1:0] accIn,
  input  logic [MAX_LANES*2*ELEM_W-1:0] srcA,
  input  logic [MAX_LANES*2*ELEM_W-1:0] srcB,
  output logic [MAX_LANES*2*ELEM_W-1:0] result
);

  localparam int LANE_W = 2 * ELEM_W;
  localparam int VEC_W  = MAX_LANES * LANE_W;
  localparam int PROD_W = 2 * (ELEM_W + 1);
  localparam int SUM_W  = LANE_W + 4;
  localparam logic signed [SUM_W-1:0] SMAX = {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SMIN = {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] UMAX = {{(SUM_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
  localparam logic [VEC_W-1:0] LIVE_MASK = {VEC_W{1'b1}} >> ((MAX_LANES - LANES) * LANE_W);

  logic [VEC_W-1:0] nextRes;

  for (genvar g = 0; g < MAX_LANES; g++) begin : gLane
    localparam bit ACTIVE = (g < LANES);
    localparam int BASE   = g * LANE_W;

    logic signed [ELEM_W:0]   aLo, aHi, bLo, bHi;
    logic signed [PROD_W-1:0] pLo, pHi;
    logic signed [SUM_W-1:0]  accX, laneSum;
    logic [LANE_W-1:0]        laneOut;

    always_comb begin
      aLo = {strobes.aSigned & srcA[BASE+ELEM_W-1], srcA[BASE +: ELEM_W]};
      aHi = {strobes.aSigned & srcA[BASE+LANE_W-1], srcA[BASE+ELEM_W +: ELEM_W]};
      bLo = {strobes.bSigned & srcB[BASE+ELEM_W-1], srcB[BASE +: ELEM_W]};
      bHi = {strobes.bSigned & srcB[BASE+LANE_W-1], srcB[BASE+ELEM_W +: ELEM_W]};
      pLo = aLo * bLo;
      pHi = aHi * bHi;
      accX = {{(SUM_W-LANE_W){strobes.accSigned & accIn[BASE+LANE_W-1]}}, accIn[BASE +: LANE_W]};
      laneSum = accX
              + {{(SUM_W-PROD_W){pLo[PROD_W-1]}}, pLo}
              + {{(SUM_W-PROD_W){pHi[PROD_W-1]}}, pHi};

      if (!ACTIVE || strobes.zeroOut) begin
        laneOut = '0;
      end else if (!strobes.satEn) begin
        laneOut = laneSum[LANE_W-1:0];
      end else if (strobes.accSigned) begin
        if (laneSum > SMAX)      laneOut = SMAX[LANE_W-1:0];
        else if (laneSum < SMIN) laneOut = SMIN[LANE_W-1:0];
        else                     laneOut = laneSum[LANE_W-1:0];
      end else begin
        if (laneSum > UMAX) laneOut = UMAX[LANE_W-1:0];
        else                laneOut = laneSum[LANE_W-1:0];
      end
    end

    // R4
    always_comb begin
      if (!strobes.accSigned && !strobes.zeroOut)
        uns_nonneg_chk: assert (!laneSum[SUM_W-1]);
    end

    assign nextRes[BASE +: LANE_W] = laneOut;
  end

  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (strobes.loadEn) result <= nextRes;
  end

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (result & ~LIVE_MASK) == '0);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadEn |=> $stable(result));

  // R9
  zero_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadEn && strobes.zeroOut) |=> (result == '0));

endmodule

// File: rtl/pair_dot_accum.sv
module pair_dot_accum
  import pda_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [2:0]   mode,
  input  logic [255:0] accIn,
  input  logic [255:0] srcA,
  input  logic [255:0] srcB,
  output logic         outValid,
  output logic [255:0] result
);

  ctrl_t strobes;

  pda_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .mode     (mode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  pda_datapath #(
    .LANES     (LANES),
    .MAX_LANES (8),
    .ELEM_W    (16)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .accIn   (accIn),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result)
  );

endmodule

// File: tb/pair_dot_accum_test.sv
`timescale 1ns/1ps
module pair_dot_accum_test;

  localparam int LANES = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [2:0]   mode = 3'b000;
  logic [255:0] accIn = '0, srcA = '0, srcB = '0;
  logic         outValid;
  logic [255:0] result;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pair_dot_accum #(.LANES(LANES)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode),
    .accIn(accIn), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .result(result)
  );

  function automatic longint extw(logic [15:0] w, bit s);
    return s ? longint'($signed(w)) : longint'(w);
  endfunction

  // Expected vector from the requirement text
  function automatic logic [255:0] model(logic [2:0] m, logic [255:0] acc,
                                         logic [255:0] a, logic [255:0] b);
    logic [255:0] r = '0;
    for (int j = 0; j < LANES; j++) begin
      bit sa, sb, sacc;
      longint s;
      logic [31:0] accL = acc[32*j +: 32];
      sa   = (m[1:0] == 2'b00);
      sb   = (m[1:0] == 2'b01);
      sacc = (m[1:0] != 2'b10);
      s = (sacc ? longint'($signed(accL)) : longint'(accL))
        + extw(a[32*j +: 16], sa) * extw(b[32*j +: 16], sb)
        + extw(a[32*j+16 +: 16], sa) * extw(b[32*j+16 +: 16], sb);
      if (m[1:0] == 2'b11) s = 0;
      else if (m[2] && sacc) begin
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        else if (s < -64'sd2147483648) s = -64'sd2147483648;
      end else if (m[2]) begin
        if (s > 64'sd4294967295) s = 64'sd4294967295;
      end
      r[32*j +: 32] = s[31:0];
    end
    return r;
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setLane(int j, logic [31:0] acc, logic [15:0] a0, logic [15:0] a1,
                         logic [15:0] b0, logic [15:0] b1);
    accIn[32*j +: 32] = acc;
    srcA[32*j +: 32]  = {a1, a0};
    srcB[32*j +: 32]  = {b1, b0};
  endtask

  task automatic fillAll(logic [31:0] acc, logic [15:0] a0, logic [15:0] a1,
                         logic [15:0] b0, logic [15:0] b1);
    for (int j = 0; j < 8; j++) setLane(j, acc, a0, a1, b0, b1);
  endtask

  // One operation: present at a negedge, result visible at the next negedge
  task automatic runOp(logic [2:0] m, string req);
    logic [255:0] exp;
    @(negedge clk);
    mode = m; inValid = 1'b1;
    exp = model(m, accIn, srcA, srcB);
    @(negedge clk);
    inValid = 1'b0;
    check(req, result, exp);
    check("R10 outValid high", {255'd0, outValid}, 256'd1);
  endtask

  task automatic testReset();
    fillAll(32'h1234_5678, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    inValid = 1'b1; mode = 3'b000;
    repeat (2) @(negedge clk);
    check("R11 result after reset", result, '0);
    check("R11 outValid after reset", {255'd0, outValid}, '0);
    inValid = 1'b0; rst = 1'b0;
  endtask

  task automatic testBasic();
    fillAll(32'd100, 16'd3, 16'd5, 16'd7, 16'd11);
    setLane(1, 32'hFFFF_FFF6, 16'hFFFE, 16'd4, 16'd9, 16'hFFFF);
    runOp(3'b000, "R1 R2 signed-by-unsigned basic");
    runOp(3'b001, "R3 unsigned-by-signed basic");
    runOp(3'b010, "R4 unsigned-by-unsigned basic");
  endtask

  task automatic testWrap();
    fillAll(32'h7FFF_0000, 16'h7FFF, 16'h7FFF, 16'hFFFF, 16'hFFFF);
    runOp(3'b000, "R5 signed wrap");
    fillAll(32'hFFFF_FFF0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    runOp(3'b010, "R5 unsigned wrap");
  endtask

  task automatic testSat();
    fillAll(32'h7FFF_0000, 16'h7FFF, 16'h7FFF, 16'hFFFF, 16'hFFFF);
    runOp(3'b100, "R6 positive clamp");
    fillAll(32'h8000_0000, 16'h8000, 16'h8000, 16'hFFFF, 16'hFFFF);
    runOp(3'b100, "R6 negative clamp su");
    fillAll(32'h8000_0000, 16'hFFFF, 16'hFFFF, 16'h8000, 16'h8000);
    runOp(3'b101, "R6 negative clamp us");
    fillAll(32'hFFFF_FFF0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    runOp(3'b110, "R7 unsigned clamp");
    fillAll(32'd5, 16'd2, 16'd3, 16'd4, 16'd6);
    runOp(3'b110, "R7 unsigned no clamp");
  endtask

  task automatic testMixedLanes();
    fillAll(32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    setLane(0, 32'h7FFF_FFF0, 16'h7FFF, 16'h7FFF, 16'hFFFF, 16'hFFFF);
    setLane(1, 32'd10, 16'd2, 16'hFFFD, 16'd3, 16'd4);
    setLane(2, 32'h8000_0010, 16'h8000, 16'h8000, 16'hFFFF, 16'hFFFF);
    setLane(3, 32'h0000_0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
    runOp(3'b100, "R6 R8 clamp next to pass-through");
    check("R8 upper lanes zero", result[255:32*LANES], '0);
  endtask

  task automatic testZeroMode();
    fillAll(32'h1234_5678, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    runOp(3'b011, "R9 code 11 zero");
    runOp(3'b111, "R9 code 11 zero with saturate");
  endtask

  task automatic testHold();
    logic [255:0] held;
    fillAll(32'd7, 16'd1, 16'd2, 16'd3, 16'd4);
    runOp(3'b010, "R10 load before hold");
    held = result;
    fillAll(32'hDEAD_BEEF, 16'h7777, 16'h8888, 16'h9999, 16'hAAAA);
    mode = 3'b000;
    repeat (2) @(negedge clk);
    check("R10 hold while idle", result, held);
    check("R10 outValid low while idle", {255'd0, outValid}, '0);
  endtask

  task automatic testMidReset();
    fillAll(32'd9, 16'd1, 16'd1, 16'd1, 16'd1);
    runOp(3'b000, "R1 load before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 mid-run reset result", result, '0);
    check("R11 mid-run reset outValid", {255'd0, outValid}, '0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failCount++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    testReset();
    testBasic();
    testWrap();
    testSat();
    testMixedLanes();
    testZeroMode();
    testHold();
    testMidReset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule